// File: doc/BRIEF.md
# VGA Sequencer and Graphics Index/Data Register File

This block is the I/O-port front end for two banks of standard VGA control registers: the sequencer bank (eight registers) and the graphics-controller bank (nine registers). Each bank has a port pair. A write to the lower port of the pair selects a register. A write to the upper port stores a byte into the register that is selected. Before the byte is stored, its reserved bits are forced to zero by a fixed mask for each register. Writes to any other port, and data writes whose selected index lies beyond the bank, are refused, and a one-cycle reject pulse is raised.

A 16-bit port write is served as two byte writes on consecutive cycles: the low byte goes to the given port and the high byte goes to the next port up. The requester holds its request while `wr_ready` is low. A mode detector watches the stored values. It raises a live flag when the adapter is in plain planar mode with the 64 KiB window, and it pulses a one-cycle cache-restart strobe each time that flag turns on. Every stored register is exported in flat form to the memory datapath.

Top module: `vga_idx_regfile`

## Requirements
- R1: After a synchronous active-low reset, every index and data register reads zero. `std_mode`, `cache_restart` and `wr_reject` are low, and `wr_ready` is high.
- R2: A byte write to port 0x3C4 selects a sequencer index. A byte write to 0x3C5 stores the masked byte into sequencer register[index], which is exported on `seq_regs[8*i+7:8*i]`. The index stays selected across further data writes.
- R3: A byte write to port 0x3CE selects a graphics index. A byte write to 0x3CF stores the masked byte into graphics register[index], which is exported on `gfx_regs[8*i+7:8*i]`.
- R4: The sequencer bits kept per index are: 0x03 at 0, 0x3D at 1, 0x0F at 2, 0x3F at 3, 0x0E at 4, none at 5 and 6, and all eight at 7.
- R5: The graphics bits kept per index are: 0x0F at 0, 1, 2, 6 and 7, 0x1F at 3, 0x03 at 4, 0x7B at 5, and all eight at 8.
- R6: A data write whose selected index is 8 or above (sequencer) or 9 or above (graphics) changes no register, and `wr_reject` is high in the following cycle.
- R7: A write to any port other than the four above changes no register, and `wr_reject` is high in the following cycle.
- R8: `std_mode` is high exactly while sequencer register 7 holds 0x00 and graphics register 6 holds 0x05, in the same cycle as the stored values.
- R9: `cache_restart` is high for exactly one cycle, the first cycle in which `std_mode` is high after being low. Leaving the mode produces no pulse.
- R10: With `wr_wide` set, the low byte is written to `wr_port` in the first cycle, while `wr_ready` is low. The high byte is written to `wr_port+1` in the next cycle, while `wr_ready` is high. Each beat is accepted or rejected on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Port write request |
| wr_wide | input | 1 | Request is 16-bit (two byte beats) |
| wr_port | input | 16 | I/O port address |
| wr_data | input | 16 | Write data; low byte used for byte writes |
| wr_ready | output | 1 | Low during the first beat of a 16-bit write; hold the request |
| wr_reject | output | 1 | Pulse: the byte beat of the previous cycle was refused |
| std_mode | output | 1 | Live standard planar mode flag |
| cache_restart | output | 1 | One-cycle pulse when standard mode is entered |
| seq_regs | output | 64 | Sequencer registers, index i at bits 8i+7:8i |
| gfx_regs | output | 72 | Graphics registers, index i at bits 8i+7:8i |

## Verification
The split of a 16-bit write and mode entry can land in the same cycle. One 16-bit write to 0x3CE with value 0x0506 selects graphics index 6 in its first beat and stores 0x05 in its second. The bench issues that write with sequencer register 7 already zero. It then checks that the register, `std_mode` and `cache_restart` all change in the cycle after the second beat, with `wr_ready` back high. It also checks that the first beat alone left the flag low. A 16-bit write to 0x3C5 is used the same way: it pairs an accepted beat with a rejected beat at 0x3C6, and the reject pulse must follow the second beat only.

// File: rtl/vga_idx_pkg.sv
// Package: shared constants and the reserved-bit keep masks for the
// sequencer and graphics-controller banks.
// Assumes byte-wide registers and 16-bit I/O port addresses.
package vga_idx_pkg;

    localparam int PORT_W   = 16;
    localparam int SEQ_REGS = 8;
    localparam int GFX_REGS = 9;

    localparam logic [PORT_W-1:0] SEQ_BASE = 16'h03C4;
    localparam logic [PORT_W-1:0] GFX_BASE = 16'h03CE;

    typedef enum logic {BANK_SEQ, BANK_GFX} bank_kind_e;

    // Bits that survive a data write, for each bank and index.
    function automatic logic [7:0] keep_mask(bank_kind_e kind, int idx);
        logic [7:0] m;
        m = 8'h00;
        if (kind == BANK_SEQ) begin
            case (idx)
                0:       m = 8'h03;
                1:       m = 8'h3D;
                2:       m = 8'h0F;
                3:       m = 8'h3F;
                4:       m = 8'h0E;
                7:       m = 8'hFF;
                default: m = 8'h00;
            endcase
        end else begin
            case (idx)
                3:       m = 8'h1F;
                4:       m = 8'h03;
                5:       m = 8'h7B;
                8:       m = 8'hFF;
                default: m = 8'h0F;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/vga_port_splitter.sv
// Splits a 16-bit port write into two byte beats on consecutive cycles.
// Beat 0 carries the low byte at wr_port and beat 1 the high byte at
// wr_port+1. Assumes the requester holds wr_en/wr_wide while wr_ready is low.
module vga_port_splitter #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_wide,
    input  logic [PW-1:0] wr_port,
    input  logic [15:0]   wr_data,
    output logic          wr_ready,
    output logic          byte_fire,
    output logic [PW-1:0] byte_port,
    output logic [7:0]    byte_val
);
    logic hi_q;
    logic first_beat;
    logic hi_beat;

    assign first_beat = wr_en & wr_wide & ~hi_q;
    assign hi_beat    = wr_en & wr_wide & hi_q;
    assign wr_ready   = ~first_beat;
    assign byte_fire  = wr_en;
    assign byte_port  = hi_beat ? (wr_port + PW'(1)) : wr_port;
    assign byte_val   = hi_beat ? wr_data[15:8] : wr_data[7:0];

    // Purpose: remember that the low beat of a wide write has been served.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= first_beat;
    end

    // R10: a stalled first beat is always followed by a ready cycle
    p_ready_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide && !wr_ready) |=> wr_ready);
    // R10: byte-sized requests never stall
    p_byte_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide) |-> wr_ready);

endmodule

// File: rtl/vga_idx_bank.sv
// One index/data register bank. A write to BASE loads the index; a write
// to BASE+1 stores the masked byte into the register that is selected.
// An index at or beyond COUNT refuses data writes. Assumes one byte beat
// per cycle.
module vga_idx_bank
    import vga_idx_pkg::*;
#(
    parameter bank_kind_e        KIND  = BANK_SEQ,
    parameter int                COUNT = 8,
    parameter int                PW    = 16,
    parameter logic [PW-1:0]     BASE  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [PW-1:0]      port,
    input  logic [7:0]         val,
    output logic               accept,
    output logic [COUNT*8-1:0] regs_flat
);
    logic [7:0] idx_q;
    logic [7:0] regs_q [COUNT];
    logic       hit_idx;
    logic       hit_dat;
    logic       in_range;

    assign hit_idx  = (port == BASE);
    assign hit_dat  = (port == BASE + PW'(1));
    assign in_range = (idx_q < 8'(COUNT));
    assign accept   = fire & (hit_idx | (hit_dat & in_range));

    // Purpose: hold the selected register index.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= 8'h00;
        else if (fire && hit_idx)  idx_q <= val;
    end

    for (genvar i = 0; i < COUNT; i++) begin : g_reg
        localparam logic [7:0] KEEP = keep_mask(KIND, i);

        // Purpose: store a data write with reserved bits cleared.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= 8'h00;
            else if (fire && hit_dat && idx_q == 8'(i))
                regs_q[i] <= val & KEEP;
        end

        assign regs_flat[8*i +: 8] = regs_q[i];

        // R4 for the sequencer bank, R5 for the graphics bank
        p_masked_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && hit_dat && idx_q == 8'(i)) |=> (regs_q[i] == ($past(val) & KEEP)));
    end

    // R6: a data write with an out-of-range index changes nothing
    p_range_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && hit_dat && !in_range) |=> $stable(regs_flat));

endmodule

// File: rtl/vga_mode_detect.sv
// Derives the live standard-mode flag from two stored registers and
// pulses a restart strobe in the first cycle that the flag is high.
// Assumes its inputs come straight from the register flops.
module vga_mode_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] seq_mode_reg,
    input  logic [7:0] gfx_misc_reg,
    output logic       std_mode,
    output logic       cache_restart
);
    logic prev_q;

    assign std_mode      = (seq_mode_reg == 8'h00) && (gfx_misc_reg == 8'h05);
    assign cache_restart = std_mode & ~prev_q;

    // Purpose: remember last cycle's flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= std_mode;
    end

    // R9: the strobe never lasts more than one cycle
    p_restart_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cache_restart |=> !cache_restart);
    // R9: leaving the mode gives no pulse
    p_no_exit_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(std_mode) |-> !cache_restart);

endmodule

// File: rtl/vga_idx_regfile.sv
// Top: VGA sequencer and graphics index/data register file. Splits wide
// port writes, routes each byte beat to both banks, flags refused beats
// one cycle later, and derives the standard-mode flag and restart strobe.
// Assumes at most one port write request at a time.
module vga_idx_regfile
    import vga_idx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_wide,
    input  logic [15:0]           wr_port,
    input  logic [15:0]           wr_data,
    output logic                  wr_ready,
    output logic                  wr_reject,
    output logic                  std_mode,
    output logic                  cache_restart,
    output logic [SEQ_REGS*8-1:0] seq_regs,
    output logic [GFX_REGS*8-1:0] gfx_regs
);
    localparam int SEQ_MODE_IDX = 7;
    localparam int GFX_MISC_IDX = 6;

    logic          byte_fire;
    logic [15:0]   byte_port;
    logic [7:0]    byte_val;
    logic          seq_ok;
    logic          gfx_ok;
    logic          reject_q;

    vga_port_splitter #(.PW(PORT_W)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_wide   (wr_wide),
        .wr_port   (wr_port),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .byte_fire (byte_fire),
        .byte_port (byte_port),
        .byte_val  (byte_val)
    );

    vga_idx_bank #(.KIND(BANK_SEQ), .COUNT(SEQ_REGS), .PW(PORT_W), .BASE(SEQ_BASE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (byte_fire),
        .port      (byte_port),
        .val       (byte_val),
        .accept    (seq_ok),
        .regs_flat (seq_regs)
    );

    vga_idx_bank #(.KIND(BANK_GFX), .COUNT(GFX_REGS), .PW(PORT_W), .BASE(GFX_BASE)) u_gfx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (byte_fire),
        .port      (byte_port),
        .val       (byte_val),
        .accept    (gfx_ok),
        .regs_flat (gfx_regs)
    );

    vga_mode_detect u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .seq_mode_reg  (seq_regs[8*SEQ_MODE_IDX +: 8]),
        .gfx_misc_reg  (gfx_regs[8*GFX_MISC_IDX +: 8]),
        .std_mode      (std_mode),
        .cache_restart (cache_restart)
    );

    // Purpose: flag a beat that no bank accepted, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= byte_fire & ~(seq_ok | gfx_ok);
    end

    assign wr_reject = reject_q;

    // R7: a reject only ever follows a write request
    p_reject_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> $past(wr_en));
    // R7: a refused beat leaves both banks untouched
    p_reject_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> ($stable(seq_regs) && $stable(gfx_regs)));

endmodule

// File: tb/vga_idx_regfile_bench.sv
module vga_idx_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_wide = 1'b0;
    logic [15:0] wr_port = '0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic        wr_reject;
    logic        std_mode;
    logic        cache_restart;
    logic [63:0] seq_regs;
    logic [71:0] gfx_regs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vga_idx_regfile u_vga_idx_regfile (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_wide       (wr_wide),
        .wr_port       (wr_port),
        .wr_data       (wr_data),
        .wr_ready      (wr_ready),
        .wr_reject     (wr_reject),
        .std_mode      (std_mode),
        .cache_restart (cache_restart),
        .seq_regs      (seq_regs),
        .gfx_regs      (gfx_regs)
    );

    function automatic logic [7:0] seq_keep(int i);
        case (i)
            0: return 8'h03;  1: return 8'h3D;  2: return 8'h0F;
            3: return 8'h3F;  4: return 8'h0E;  7: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] gfx_keep(int i);
        case (i)
            3: return 8'h1F;  4: return 8'h03;  5: return 8'h7B;
            8: return 8'hFF;
            default: return 8'h0F;
        endcase
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One byte write; returns at the negedge after the capturing edge.
    task automatic put_byte(logic [15:0] port, logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_wide = 1'b0; wr_port = port; wr_data = {8'h00, val};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 seq_regs", seq_regs, 0);
        check("R1 gfx_regs", gfx_regs, 0);
        check("R1 std_mode", std_mode, 0);
        check("R1 cache_restart", cache_restart, 0);
        check("R1 wr_ready", wr_ready, 1);
        check("R1 wr_reject", wr_reject, 0);
    endtask

    task automatic t_seq_masks;
        for (int i = 0; i < 8; i++) begin
            put_byte(16'h03C4, 8'(i));
            put_byte(16'h03C5, 8'hFF);
            check("R2/R4 seq keep", seq_regs[8*i +: 8], seq_keep(i));
            check("R2 seq accepted", wr_reject, 0);
        end
        // index stays selected (7): a second data write reuses it
        put_byte(16'h03C5, 8'hA5);
        check("R2 index held", seq_regs[63:56], 8'hA5);
        check("R4 seq idx0 kept", seq_regs[7:0], 8'h03);
    endtask

    task automatic t_gfx_masks;
        for (int i = 0; i < 9; i++) begin
            put_byte(16'h03CE, 8'(i));
            put_byte(16'h03CF, 8'hFF);
            check("R3/R5 gfx keep", gfx_regs[8*i +: 8], gfx_keep(i));
        end
        check("R8 not std with gfx6=0F", std_mode, 0);
    endtask

    task automatic t_range;
        logic [63:0] s0;
        logic [71:0] g0;
        s0 = seq_regs; g0 = gfx_regs;
        put_byte(16'h03C4, 8'h08);
        check("R6 index write ok", wr_reject, 0);
        put_byte(16'h03C5, 8'h77);
        check("R6 seq reject", wr_reject, 1);
        check("R6 seq unchanged", seq_regs, s0);
        put_byte(16'h03CE, 8'h09);
        put_byte(16'h03CF, 8'h77);
        check("R6 gfx reject", wr_reject, 1);
        check("R6 gfx unchanged", gfx_regs, g0);
        @(negedge clk);
        check("R6 reject is a pulse", wr_reject, 0);
    endtask

    task automatic t_bad_port;
        logic [63:0] s0;
        logic [71:0] g0;
        s0 = seq_regs; g0 = gfx_regs;
        put_byte(16'h03C6, 8'h12);
        check("R7 reject 3C6", wr_reject, 1);
        put_byte(16'h13C5, 8'h34);
        check("R7 reject 13C5", wr_reject, 1);
        check("R7 seq unchanged", seq_regs, s0);
        check("R7 gfx unchanged", gfx_regs, g0);
    endtask

    task automatic t_mode;
        put_byte(16'h03C4, 8'h07);
        put_byte(16'h03C5, 8'h00);
        check("R8 seq7 zero only", std_mode, 0);
        put_byte(16'h03CE, 8'h06);
        put_byte(16'h03CF, 8'h05);
        check("R8 std_mode set", std_mode, 1);
        check("R9 restart on entry", cache_restart, 1);
        @(negedge clk);
        check("R9 restart one cycle", cache_restart, 0);
        check("R8 std_mode stays", std_mode, 1);
        put_byte(16'h03CF, 8'h01);
        check("R8 std_mode cleared", std_mode, 0);
        check("R9 no pulse on exit", cache_restart, 0);
    endtask

    task automatic t_wide;
        // wide write to graphics pair: index 6 then data 0x05 -> mode entry
        @(negedge clk);
        wr_en = 1'b1; wr_wide = 1'b1; wr_port = 16'h03CE; wr_data = 16'h0506;
        #1;
        check("R10 ready low first beat", wr_ready, 0);
        @(negedge clk);
        check("R10 ready high second beat", wr_ready, 1);
        check("R8 low beat alone no mode", std_mode, 0);
        check("R10 low beat accepted", wr_reject, 0);
        @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0;
        check("R10 high byte at port+1", gfx_regs[55:48], 8'h05);
        check("R8 mode after wide", std_mode, 1);
        check("R9 restart after wide", cache_restart, 1);
        // wide write to 0x3C4: index 2, data 0x0F
        @(negedge clk);
        wr_en = 1'b1; wr_wide = 1'b1; wr_port = 16'h03C4; wr_data = 16'h0F02;
        repeat (2) @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0;
        check("R10 seq wide store", seq_regs[23:16], 8'h0F);
        // wide write at 0x3C5: low beat stored (idx 2), high beat at 0x3C6 refused
        @(negedge clk);
        wr_en = 1'b1; wr_wide = 1'b1; wr_port = 16'h03C5; wr_data = 16'hEE03;
        @(negedge clk);
        check("R10 low beat ok", wr_reject, 0);
        check("R10 low beat stored", seq_regs[23:16], 8'h03);
        @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0;
        check("R7 high beat at 3C6 rejected", wr_reject, 1);
        check("R7 seq2 kept", seq_regs[23:16], 8'h03);
    endtask

    initial begin
        t_reset();
        t_seq_masks();
        t_gfx_masks();
        t_range();
        t_bad_port();
        t_mode();
        t_wide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule